// File: doc/BRIEF.md
# Audio Serial Clock Generator with Odd-Ratio Prescaler

This block derives the timing of an audio serial link from a single reference clock. A prescaler divides the reference by a 9-bit factor N whose upper eight bits are a programmable divisor and whose lowest bit is an odd flag. That allows both even and odd ratios. The prescaled clock either drives the serial bit clock directly, or, when a master clock is requested, becomes the master clock at 256 times the sample rate. In that case the bit clock is divided down from it.

Everything runs in the reference clock domain. The bit clock comes out as a level plus one-cycle rise and fall pulses, so a serial framer can shift data on them. A frame strobe marks the first bit-clock period of every stereo frame. Configuration is captured only while the generator is disabled. Enabling the generator restarts every counter from zero.

Top module: `i2sclk_gen`

## Requirements
- R1: While reset is active, and from the second clock edge after `enable` is deasserted, every output is low.
- R2: The prescale factor is N = 2*d + odd_i, with d = div_i, except that div_i values 0 and 1 count as d = 2. Without a master clock, `sck_o` repeats every N reference cycles. With a master clock, `mck_o` repeats every N reference cycles.
- R3: Each prescaled period is high for d + odd_i cycles and then low for d cycles. The high phase comes first.
- R4: When `mck_req_i` is 1, `mck_oe` is high while the generator runs and `mck_o` carries the prescaled clock. When `mck_req_i` is 0, both `mck_oe` and `mck_o` stay low.
- R5: With a master clock, the bit clock period is N*R cycles. R is 8 when `slot_long_i` = 0 (16-bit slots) and 4 when `slot_long_i` = 1 (32-bit slots). The bit clock is high for the first N*R/2 cycles of each period.
- R6: `sck_rise_o` and `sck_fall_o` are each high for exactly one cycle: the first cycle in which `sck_o` is high, or the first cycle in which it is low.
- R7: `frame_stb_o` pulses once every 2*S bit-clock periods, on the rising bit-clock cycle. S is 16 when `slot_long_i` = 0 and 32 when it is 1. The frame period is 256*N cycles with a master clock and 2*S*N cycles without one.
- R8: Configuration inputs are sampled only while `enable` is low. Changes made while the generator runs have no effect on any output.
- R9: The first cycle after `enable` is sampled high is cycle zero of every counter. In that cycle `sck_rise_o` and `frame_stb_o` are both high, and `sck_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator; low clears counters and admits new configuration |
| div_i | input | 8 | Divisor d (upper bits of N) |
| odd_i | input | 1 | Odd flag (bit 0 of N) |
| mck_req_i | input | 1 | 1 requests the master clock output |
| slot_long_i | input | 1 | Slot length: 0 = 16 bits, 1 = 32 bits |
| mck_o | output | 1 | Master clock, 256 times the sample rate |
| mck_oe | output | 1 | Output enable for the master clock pin |
| sck_o | output | 1 | Bit clock level |
| sck_rise_o | output | 1 | One-cycle pulse on bit clock rising |
| sck_fall_o | output | 1 | One-cycle pulse on bit clock falling |
| frame_stb_o | output | 1 | One-cycle pulse at start of each frame |

## Verification
The bench uses the default slot lengths of 16 and 32 and a multiplier of 256. This keeps a full master-clock frame at divisor 5 within about 2,800 cycles. It therefore sweeps divisors 0, 1, 2, 3 and 5, both odd settings, both clock paths and both slot lengths, and compares every output in every cycle of at least one whole frame against closed-form expectations. Two runs at divisor 255 reach the largest factors, 510 and 511, on the bit-clock-only path. A separate run changes every configuration input mid-frame to show that the change is ignored.

// File: rtl/i2sclk_pkg.sv
package i2sclk_pkg;
  localparam int DIV_W  = 8;
  localparam int FACT_W = DIV_W + 1;
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             odd;
    logic             mck_en;
    logic             slot_long;
  } clk_cfg_t;

  // Divisors below the minimum are promoted to it.
  function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] d);
    return (d < DIV_MIN) ? DIV_MIN : d;
  endfunction

  // N = 2*d + odd : divisor in bits FACT_W-1..1, odd flag in bit 0.
  function automatic logic [FACT_W-1:0] div_factor(input logic [DIV_W-1:0] d, input logic odd);
    return {clamp_div(d), odd};
  endfunction

  // Length of the high phase: d + odd.
  function automatic logic [FACT_W-1:0] high_len(input logic [DIV_W-1:0] d, input logic odd);
    return {1'b0, clamp_div(d)} + {{DIV_W{1'b0}}, odd};
  endfunction
endpackage

// File: rtl/i2sclk_prescaler.sv
module i2sclk_prescaler
  import i2sclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [FACT_W-1:0] factor,
  input  logic [FACT_W-1:0] high,
  output logic              base_lvl,
  output logic              base_rise,
  output logic              base_fall,
  output logic              base_end
);
  logic [FACT_W-1:0] cnt;
  logic              cnt_last;

  assign cnt_last = (cnt == (factor - 1'b1));

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (cnt_last) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign base_lvl  = run && (cnt < high);
  assign base_rise = run && (cnt == '0);
  assign base_fall = run && (cnt == high);
  assign base_end  = run && cnt_last;

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < factor));

  assert_high_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    base_fall |-> ($past(base_lvl) && !base_lvl));
endmodule

// File: rtl/i2sclk_bitdiv.sv
module i2sclk_bitdiv #(
  parameter int RAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             mck_mode,
  input  logic [RAT_W-1:0] ratio,
  input  logic             base_lvl,
  input  logic             base_rise,
  input  logic             base_fall,
  input  logic             base_end,
  output logic             sck_lvl,
  output logic             sck_rise,
  output logic             sck_fall,
  output logic             sck_end
);
  localparam int BC_W = RAT_W - 1;

  logic [BC_W-1:0]  bcnt;
  logic [RAT_W-1:0] bcnt_x;
  logic [RAT_W-1:0] half;
  logic             b_last;

  assign bcnt_x = {1'b0, bcnt};
  assign half   = ratio >> 1;
  assign b_last = (bcnt_x == (ratio - 1'b1));

  always_ff @(posedge clk) begin
    if (!rst_n)                   bcnt <= '0;
    else if (!run || !mck_mode)   bcnt <= '0;
    else if (base_end)            bcnt <= b_last ? '0 : bcnt + 1'b1;
  end

  always_comb begin
    if (mck_mode) begin
      sck_lvl  = run && (bcnt_x < half);
      sck_rise = base_rise && (bcnt == '0);
      sck_fall = base_rise && (bcnt_x == half);
      sck_end  = base_end && b_last;
    end else begin
      sck_lvl  = base_lvl;
      sck_rise = base_rise;
      sck_fall = base_fall;
      sck_end  = base_end;
    end
  end

  assert_bcnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (bcnt_x < ratio));
endmodule

// File: rtl/i2sclk_framer.sv
module i2sclk_framer #(
  parameter int SHORT_SLOT = 16,
  parameter int LONG_SLOT  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slot_long,
  input  logic sck_rise,
  input  logic sck_end,
  output logic frame_stb
);
  localparam int FR_W = $clog2(2 * LONG_SLOT);
  localparam logic [FR_W-1:0] LAST_S = FR_W'(2 * SHORT_SLOT - 1);
  localparam logic [FR_W-1:0] LAST_L = FR_W'(2 * LONG_SLOT - 1);

  logic [FR_W-1:0] scnt;
  logic [FR_W-1:0] last_bit;

  assign last_bit = slot_long ? LAST_L : LAST_S;

  always_ff @(posedge clk) begin
    if (!rst_n)       scnt <= '0;
    else if (!run)    scnt <= '0;
    else if (sck_end) scnt <= (scnt == last_bit) ? '0 : scnt + 1'b1;
  end

  assign frame_stb = sck_rise && (scnt == '0);

  assert_scnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !slot_long) |-> (scnt <= LAST_S));
endmodule

// File: rtl/i2sclk_gen.sv
module i2sclk_gen
  import i2sclk_pkg::*;
#(
  parameter int SHORT_SLOT = 16,
  parameter int LONG_SLOT  = 32,
  parameter int MCK_MULT   = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_i,
  input  logic             odd_i,
  input  logic             mck_req_i,
  input  logic             slot_long_i,
  output logic             mck_o,
  output logic             mck_oe,
  output logic             sck_o,
  output logic             sck_rise_o,
  output logic             sck_fall_o,
  output logic             frame_stb_o
);
  localparam int RAT_SHORT = MCK_MULT / (2 * SHORT_SLOT);
  localparam int RAT_LONG  = MCK_MULT / (2 * LONG_SLOT);
  localparam int RAT_W     = $clog2(RAT_SHORT) + 1;

  clk_cfg_t          cfg_q;
  logic              run;
  logic [FACT_W-1:0] factor, high;
  logic [RAT_W-1:0]  ratio;

  // Configuration is admitted only while disabled.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      run   <= 1'b0;
    end else begin
      run <= enable;
      if (!enable) cfg_q <= '{div: div_i, odd: odd_i, mck_en: mck_req_i, slot_long: slot_long_i};
    end
  end

  assign factor = div_factor(cfg_q.div, cfg_q.odd);
  assign high   = high_len(cfg_q.div, cfg_q.odd);
  assign ratio  = cfg_q.slot_long ? RAT_W'(RAT_LONG) : RAT_W'(RAT_SHORT);

  logic base_lvl, base_rise, base_fall, base_end;
  logic sck_end;

  i2sclk_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .factor(factor), .high(high),
    .base_lvl(base_lvl), .base_rise(base_rise), .base_fall(base_fall), .base_end(base_end)
  );

  i2sclk_bitdiv #(.RAT_W(RAT_W)) u_bit (
    .clk(clk), .rst_n(rst_n), .run(run), .mck_mode(cfg_q.mck_en), .ratio(ratio),
    .base_lvl(base_lvl), .base_rise(base_rise), .base_fall(base_fall), .base_end(base_end),
    .sck_lvl(sck_o), .sck_rise(sck_rise_o), .sck_fall(sck_fall_o), .sck_end(sck_end)
  );

  i2sclk_framer #(.SHORT_SLOT(SHORT_SLOT), .LONG_SLOT(LONG_SLOT)) u_frm (
    .clk(clk), .rst_n(rst_n), .run(run), .slot_long(cfg_q.slot_long),
    .sck_rise(sck_rise_o), .sck_end(sck_end), .frame_stb(frame_stb_o)
  );

  assign mck_oe = run && cfg_q.mck_en;
  assign mck_o  = mck_oe && base_lvl;

  assert_sck_rise_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise_o |-> (sck_o && !$past(sck_o)));

  assert_sck_fall_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sck_fall_o |-> (!sck_o && $past(sck_o)));

  assert_mck_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mck_oe |-> !mck_o);

  assert_frame_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb_o |-> sck_rise_o);

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(cfg_q));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (sck_rise_o && frame_stb_o && sck_o));
endmodule

// File: tb/tb_i2sclk_gen.sv
module tb_i2sclk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] div_i = 8'd0;
  logic       odd_i = 1'b0, mck_req_i = 1'b0, slot_long_i = 1'b0;
  logic       mck_o, mck_oe, sck_o, sck_rise_o, sck_fall_o, frame_stb_o;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  i2sclk_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_i(div_i), .odd_i(odd_i),
    .mck_req_i(mck_req_i), .slot_long_i(slot_long_i), .mck_o(mck_o), .mck_oe(mck_oe),
    .sck_o(sck_o), .sck_rise_o(sck_rise_o), .sck_fall_o(sck_fall_o), .frame_stb_o(frame_stb_o)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int outs_now();
    return {26'd0, mck_o, mck_oe, sck_o, sck_rise_o, sck_fall_o, frame_stb_o};
  endfunction

  task automatic run_cfg(input int dv, input int od, input int mk, input int sl, input bit perturb);
    int d  = (dv < 2) ? 2 : dv;
    int n  = 2 * d + od;
    int h  = d + od;
    int r  = mk ? (sl ? 4 : 8) : 1;
    int p  = n * r;
    int s  = sl ? 32 : 16;
    int f  = p * 2 * s;
    int win = perturb ? f + 64 : (mk ? f + 2 * n : 2 * f + 3);
    int e_base = 0, e_sck = 0, e_pulse = 0, e_frame = 0, e_mck = 0, hi = 0;
    int first = 0;
    @(negedge clk);
    enable = 1'b0;
    div_i = dv[7:0]; odd_i = od[0]; mck_req_i = mk[0]; slot_long_i = sl[0];
    repeat (3) @(negedge clk);
    check(outs_now() == 0, "R1", "outputs while disabled", outs_now(), 0);
    enable = 1'b1;
    for (int t = 0; t < win; t++) begin
      @(negedge clk);
      begin
        bit b_e  = (t % n) < h;
        bit sk_e = mk ? (((t / n) % r) < r / 2) : b_e;
        bit ri_e = (t % p) == 0;
        bit fa_e = mk ? ((t % p) == p / 2) : ((t % n) == h);
        bit fr_e = (t % f) == 0;
        if ((mk ? mck_o : sck_o) != b_e) e_base++;
        if (sck_o != sk_e) e_sck++;
        if (sck_rise_o != ri_e || sck_fall_o != fa_e) e_pulse++;
        if (frame_stb_o != fr_e) e_frame++;
        if (mck_oe != mk[0] || (!mk && mck_o)) e_mck++;
        if (t < n && (mk ? mck_o : sck_o)) hi++;
        if (t == 0) first = {29'd0, sck_rise_o, frame_stb_o, sck_o};
      end
      if (perturb && t == win / 2) begin
        div_i = 8'd9; odd_i = ~odd_i; mck_req_i = ~mck_req_i; slot_long_i = ~slot_long_i;
      end
    end
    if (perturb) begin
      check(e_base + e_sck + e_pulse + e_frame + e_mck == 0, "R8",
            "mismatches after mid-run config change", e_base + e_sck + e_pulse + e_frame + e_mck, 0);
    end else begin
      check(e_base == 0, "R2", "prescaled clock mismatching cycles", e_base, 0);
      check(hi == h, "R3", "high cycles in first prescaled period", hi, h);
      check(e_mck == 0, "R4", "master clock pin mismatching cycles", e_mck, 0);
      if (mk) check(e_sck == 0, "R5", "bit clock mismatching cycles", e_sck, 0);
      check(e_pulse == 0, "R6", "edge pulse mismatching cycles", e_pulse, 0);
      check(e_frame == 0, "R7", "frame strobe mismatching cycles", e_frame, 0);
      check(first == 7, "R9", "rise/frame/sck at restart", first, 7);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int dl[5] = '{0, 1, 2, 3, 5};
    repeat (4) @(negedge clk);
    check(outs_now() == 0, "R1", "outputs in reset", outs_now(), 0);
    enable = 1'b1;
    repeat (2) @(negedge clk);
    check(outs_now() == 0, "R1", "outputs in reset with enable", outs_now(), 0);
    enable = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++)
      for (int od = 0; od < 2; od++)
        for (int mk = 0; mk < 2; mk++)
          for (int sl = 0; sl < 2; sl++)
            run_cfg(dl[i], od, mk, sl, 1'b0);
    run_cfg(255, 1, 0, 0, 1'b0);
    run_cfg(255, 0, 0, 1, 1'b0);
    run_cfg(3, 0, 1, 1, 1'b1);
    run_cfg(3, 1, 0, 0, 1'b1);
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check(outs_now() == 0, "R1", "outputs after final disable", outs_now(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule